// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus (one clock line, one shared open-drain data line). It holds a small bank of byte registers that set up a frequency synthesizer elsewhere on the chip. A fast system clock oversamples both bus lines. Each line first passes through a synchronizer. Start and stop conditions, and the rising and falling edges of the serial clock, are then detected in the system clock domain. The block answers one 7-bit address that is set by a parameter. It acknowledges by asserting a pull-low enable for the data line.

In a write, the first two bytes after the address byte are throwaway bytes and are not stored. The next three bytes fill the register bank in order; the last of these is held but has no defined use. Any further bytes are acknowledged and discarded. A read returns the stored bytes in the order they were written, most significant bit first, and it ends when the master declines to acknowledge. The bank is always visible as one parallel output vector.

Top module: `twowire_cfg_slave`

## Requirements
- R1: After synchronous reset, the pull-low output is 0 and all register bytes read 0.
- R2: A stop condition (data rises while the serial clock is high) returns the block to idle. Clock pulses that arrive later without a new start get no acknowledge.
- R3: When the first byte after a start carries the parameter address DEV_ADDR in bits 7..1, the block pulls data low for the whole ninth clock pulse. Bit 0 selects the direction: 0 for write, 1 for read.
- R4: An address byte that does not match gets no acknowledge. The block then never pulls the line and stores nothing until the next start.
- R5: In a write, the first two bytes after the address are acknowledged and not stored.
- R6: The next three write bytes are stored in order into byte 0, 1 and 2, each acknowledged. Byte k appears on cfg_bytes_o[8k+7:8k]. Bytes that are not written keep their value.
- R7: Write bytes beyond the third stored byte are acknowledged but change no stored byte.
- R8: In a read, the block drives stored bytes 0, 1, 2 in turn, most significant bit first, pulling low for each 0 bit. Reads past byte 2 return 8'hFF, so the line is left released.
- R9: When the master does not acknowledge a read byte, the block releases the line and drives nothing until the next start.
- R10: A repeated start (a start with no stop before it) restarts address reception and keeps the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Data line as seen on the bus (wired-AND level) |
| sda_pull_o | output | 1 | 1 = pull the data line low, 0 = release it |
| cfg_bytes_o | output | 8*NUM_REGS | Stored register bytes, byte 0 in the low bits |

## Verification
Each bus line passes through two synchronizer flops, and the state register follows them. So sda_pull_o and cfg_bytes_o change on the third system-clock edge after the bus line that caused the change. Every result is triggered by a serial clock falling edge. The bench changes bus lines only on the falling edge of the system clock, and it holds each bus level for twelve system clocks. It does not compare during the first four cycles after any bus change, and after that it compares both outputs with its model on every cycle. This way each expected value is checked only after its due cycle, and always before the next bus event.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK,
    ST_SKIP
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int N_LINES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] raw_i,
  output logic [N_LINES-1:0] now_o,
  output logic [N_LINES-1:0] prev_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [1:0] meta;
    logic       last;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta <= 2'b11;
        last <= 1'b1;
      end else begin
        meta <= {meta[0], raw_i[g]};
        last <= meta[1];
      end
    end
    assign now_o[g]  = meta[1];
    assign prev_o[g] = last;
  end
endmodule

// File: rtl/tw_bank.sv
module tw_bank #(
  parameter int NUM_REGS = 3,
  parameter int IW       = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] bytes_o
);
  logic [7:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= 8'h00;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wr_idx == IW'(i)) mem[i] <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign bytes_o[g*8 +: 8] = mem[g];
  end

  // R7: stores never aim outside the bank
  a_r7_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ({1'b0, wr_idx} < (IW+1)'(NUM_REGS)));
  // R6: bytes change only through a write
  a_r6_hold_unless_written: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bytes_o));
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h5A,
  parameter int         NUM_DUMMY = 2,
  parameter int         NUM_REGS  = 3,
  parameter int         IW        = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_now,
  input  logic                  scl_prev,
  input  logic                  sda_now,
  input  logic                  sda_prev,
  input  logic [NUM_REGS*8-1:0] bank_i,
  output logic                  wr_en,
  output logic [IW-1:0]         wr_idx,
  output logic [7:0]            wr_data,
  output logic                  pull_o
);
  localparam int CW = $clog2(NUM_DUMMY + NUM_REGS + 1);
  localparam int RW = $clog2(NUM_REGS + 1);
  localparam logic [CW-1:0] BMAX  = CW'(NUM_DUMMY + NUM_REGS);
  localparam logic [CW-1:0] DUMMY = CW'(NUM_DUMMY);
  localparam logic [RW-1:0] RMAX  = RW'(NUM_REGS);

  tw_state_e     state;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [7:0]    tx;
  logic          rw;
  logic          nack;
  logic [CW-1:0] bcnt;
  logic [RW-1:0] rd_idx;
  logic [7:0]    rd_byte;
  logic          pull;

  wire scl_rise  = scl_now & ~scl_prev;
  wire scl_fall  = ~scl_now & scl_prev;
  wire start_det = scl_now & scl_prev & sda_prev & ~sda_now;
  wire stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
  wire byte_end  = scl_fall && (bitcnt == 4'd8);

  always_comb begin
    rd_byte = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == RW'(i)) rd_byte = bank_i[i*8 +: 8];
  end

  assign wr_en   = (state == ST_WBYTE) && byte_end && !start_det && !stop_det &&
                   (bcnt >= DUMMY) && (bcnt < BMAX);
  assign wr_idx  = IW'(bcnt - DUMMY);
  assign wr_data = shreg;
  assign pull_o  = pull;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      tx     <= '0;
      rw     <= 1'b0;
      nack   <= 1'b0;
      bcnt   <= '0;
      rd_idx <= '0;
      pull   <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      rd_idx <= '0;
      pull   <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE;
      pull  <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WBYTE: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_now};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_end) begin
            bitcnt <= '0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                pull  <= 1'b1;
                rw    <= shreg[0];
                state <= ST_AACK;
              end else begin
                state <= ST_SKIP;
              end
            end else begin
              pull  <= 1'b1;
              state <= ST_WACK;
              if (bcnt != BMAX) bcnt <= bcnt + 1'b1;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          bitcnt <= '0;
          bcnt   <= '0;
          if (rw) begin
            tx    <= rd_byte;
            pull  <= ~rd_byte[7];
            state <= ST_RBYTE;
            if (rd_idx != RMAX) rd_idx <= rd_idx + 1'b1;
          end else begin
            pull  <= 1'b0;
            state <= ST_WBYTE;
          end
        end
        ST_WACK: if (scl_fall) begin
          pull   <= 1'b0;
          bitcnt <= '0;
          state  <= ST_WBYTE;
        end
        ST_RBYTE: if (scl_fall) begin
          if (bitcnt == 4'd7) begin
            pull   <= 1'b0;
            bitcnt <= '0;
            state  <= ST_RACK;
          end else begin
            bitcnt <= bitcnt + 4'd1;
            tx     <= tx << 1;
            pull   <= ~tx[6];
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack <= sda_now;
          end else if (scl_fall) begin
            if (nack) begin
              state <= ST_SKIP;
            end else begin
              tx    <= rd_byte;
              pull  <= ~rd_byte[7];
              state <= ST_RBYTE;
              if (rd_idx != RMAX) rd_idx <= rd_idx + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R2: a stop leaves the block idle with the line released
  a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !start_det) |=> (state == ST_IDLE && !pull));
  // R4: a skipped transfer never drives the line
  a_r4_skip_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !pull);
  // R9: the master's acknowledge slot is never driven by the slave
  a_r9_rack_released: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RACK) |-> !pull);
  // R3: the address acknowledge holds until the serial clock falls
  a_r3_ack_held: assert property (@(posedge clk) disable iff (rst)
    (state == ST_AACK && !scl_fall && !start_det && !stop_det) |=>
      (state == ST_AACK && pull));
endmodule

// File: rtl/twowire_cfg_slave.sv
module twowire_cfg_slave #(
  parameter logic [6:0] DEV_ADDR  = 7'h5A,
  parameter int         NUM_DUMMY = 2,
  parameter int         NUM_REGS  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  output logic [NUM_REGS*8-1:0] cfg_bytes_o
);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [1:0]    line_now, line_prev;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [7:0]    wr_data;

  tw_sync #(.N_LINES(2)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_i  ({scl_i, sda_i}),
    .now_o  (line_now),
    .prev_o (line_prev)
  );

  tw_ctrl #(
    .DEV_ADDR (DEV_ADDR),
    .NUM_DUMMY(NUM_DUMMY),
    .NUM_REGS (NUM_REGS),
    .IW       (IW)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .scl_now (line_now[1]),
    .scl_prev(line_prev[1]),
    .sda_now (line_now[0]),
    .sda_prev(line_prev[0]),
    .bank_i  (cfg_bytes_o),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .pull_o  (sda_pull_o)
  );

  tw_bank #(.NUM_REGS(NUM_REGS), .IW(IW)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .bytes_o(cfg_bytes_o)
  );
endmodule

// File: tb/twowire_cfg_slave_bench.sv
module twowire_cfg_slave_bench;
  localparam logic [6:0] ADDR = 7'h5A;
  localparam int HALF = 12;
  localparam int SKIP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic pull;
  logic [23:0] cfg;
  wire  sda_line = sda_m & ~pull;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] exp_cfg [3] = '{8'h00, 8'h00, 8'h00};

  always #4 clk = ~clk;

  twowire_cfg_slave u_twowire_cfg_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(pull), .cfg_bytes_o(cfg)
  );

  function automatic logic [23:0] exp_vec();
    return {exp_cfg[2], exp_cfg[1], exp_cfg[0]};
  endfunction

  task automatic compare(input logic ep, input string req);
    checks++;
    if (pull !== ep || cfg !== exp_vec()) begin
      errs++;
      $display("FAIL %s t=%0t pull=%b exp=%b cfg=%h exp=%h",
               req, $time, pull, ep, cfg, exp_vec());
    end
  endtask

  task automatic tick(input int n, input logic ep, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i >= SKIP) compare(ep, req);
    end
  endtask

  task automatic pulse(input logic d, input logic ep, input string req);
    sda_m = d;
    tick(HALF, ep, req);
    scl_m = 1'b1;
    tick(HALF, ep, req);
    scl_m = 1'b0;
  endtask

  task automatic bus_start(input string req);
    sda_m = 1'b1; tick(HALF, 1'b0, req);
    scl_m = 1'b1; tick(HALF, 1'b0, req);
    sda_m = 1'b0; tick(HALF, 1'b0, req);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop(input string req);
    sda_m = 1'b0; tick(HALF, 1'b0, req);
    scl_m = 1'b1; tick(HALF, 1'b0, req);
    sda_m = 1'b1; tick(HALF, 1'b0, req);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ack, input string req);
    for (int i = 7; i >= 0; i--) pulse(b[i], 1'b0, req);
    pulse(1'b1, ack, req);
  endtask

  // bytes after the address; k = position counted from the first dummy
  task automatic write_body(input logic [7:0] data [], input logic match);
    for (int k = 0; k < data.size(); k++) begin
      for (int i = 7; i >= 0; i--) pulse(data[k][i], 1'b0, "R6");
      if (match && k >= 2 && k < 5) exp_cfg[k-2] = data[k];
      pulse(1'b1, match, (k < 2) ? "R5" : (k < 5) ? "R6" : "R7");
    end
  endtask

  task automatic read_body(input int n, input string req);
    for (int j = 0; j < n; j++) begin
      logic [7:0] e;
      e = (j < 3) ? exp_cfg[j] : 8'hFF;
      for (int i = 7; i >= 0; i--) pulse(1'b1, ~e[i], req);
      pulse((j == n - 1) ? 1'b1 : 1'b0, 1'b0, req);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    tick(6, 1'b0, "R1");

    // R3 R5 R6: matching write, two dummies then three data bytes
    bus_start("R3");
    send_byte({ADDR, 1'b0}, 1'b1, "R3");
    write_body('{8'h11, 8'h22, 8'hA5, 8'h3C, 8'hF0}, 1'b1);
    bus_stop("R6");

    // R7: extra bytes acknowledged and dropped
    bus_start("R7");
    send_byte({ADDR, 1'b0}, 1'b1, "R3");
    write_body('{8'hEE, 8'hDD, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05}, 1'b1);
    bus_stop("R7");

    // R4: other address, nothing acked or stored
    bus_start("R4");
    send_byte({7'h33, 1'b0}, 1'b0, "R4");
    write_body('{8'h99, 8'h88, 8'h77, 8'h66}, 1'b0);
    bus_stop("R4");

    // R2: after a stop, a matching byte without a start is ignored
    scl_m = 1'b0; tick(HALF, 1'b0, "R2");
    send_byte({ADDR, 1'b0}, 1'b0, "R2");
    for (int i = 0; i < 8; i++) pulse(1'b0, 1'b0, "R2");
    pulse(1'b1, 1'b0, "R2");

    // R8: read all three bytes plus one past the end
    bus_start("R8");
    send_byte({ADDR, 1'b1}, 1'b1, "R3");
    read_body(4, "R8");
    // R9: released after the NACK
    for (int i = 0; i < 9; i++) pulse(1'b1, 1'b0, "R9");
    bus_stop("R9");

    // R10: partial write, repeated start, read back
    bus_start("R10");
    send_byte({ADDR, 1'b0}, 1'b1, "R3");
    write_body('{8'h00, 8'hFF, 8'h7E}, 1'b1);
    bus_start("R10");
    send_byte({ADDR, 1'b1}, 1'b1, "R10");
    read_body(3, "R10");
    bus_stop("R10");

    // R9: NACK after the first byte, later clocks undriven
    bus_start("R9");
    send_byte({ADDR, 1'b1}, 1'b1, "R3");
    read_body(1, "R9");
    for (int i = 0; i < 9; i++) pulse(1'b1, 1'b0, "R9");
    bus_stop("R9");

    // R6: final bank contents (7E written last, 02 and 03 kept)
    @(negedge clk);
    checks++;
    if (cfg !== 24'h03027E) begin
      errs++;
      $display("FAIL R6 final cfg=%h exp=%h", cfg, 24'h03027E);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule